// File: doc/BRIEF.md
# Segment-Mapped Address Translator

This block is the front stage of a 32-bit virtual-to-physical address translator. Each access arrives as a one-cycle pulse carrying a virtual address. Alongside it come a global configuration word, an MMU configuration word and two 32-bit segment base words. The block sorts every access into one of three routes.

With translation switched off, the address passes through unchanged. In a segment the configuration marks as direct-mapped, the top four address bits are replaced by a 4-bit base value. In these two routes the result appears in the same cycle with read, write and execute all granted. Every other access goes to an external paged lookup path. The block raises a request to that path and forwards the address. It then registers the path's answer (frame number, rights, miss flag) and presents it one cycle after the answer arrives.

The caller issues a new access only while `busy` is low. `busy` covers the whole time a paged lookup is open.

Top module: `seg_xlate`

## Requirements
- R1: When bits 2 and 3 of `glb_cfg` are both zero, an access gives `res_valid`=1 in the same cycle, with `res_paddr` equal to `acc_vaddr`, `res_perm`=3'b111 (bit 0 read, bit 1 write, bit 2 exec), `res_miss`=0 and `pg_req`=0.
- R2: Translation is on when bit 2 or bit 3 of `glb_cfg` is set. Every other bit of `glb_cfg` has no effect on the route taken.
- R3: With translation on, the segment number is `acc_vaddr[31:28]`. The access is direct-mapped exactly when `mmu_cfg` bit [segment number] is 1. Otherwise it takes the paged route.
- R4: Segments 0 to 7 read their 4-bit base from `seg_base_lo`, and segments 8 to 15 from `seg_base_hi`. In the chosen word the base sits at bits [(s mod 8)*4 +: 4].
- R5: A direct-mapped access gives, in the same cycle, `res_paddr` = {base, `acc_vaddr[27:0]`}, `res_perm`=3'b111 and `pg_req`=0.
- R6: A paged access raises `pg_req` in the same cycle with `pg_vaddr`=`acc_vaddr`. `res_valid` stays 0 in that cycle.
- R7: After a paged request, a cycle with `pg_rsp_valid`=1 is followed one cycle later by a single cycle with `res_valid`=1. In that cycle `res_paddr` = `pg_rsp_pfn` shifted left by 13, and `res_perm` and `res_miss` are the values the page path returned.
- R8: `busy` is 1 from the cycle after a paged request up to and including the cycle its result is shown. A `pg_rsp_valid` with no open request is ignored and gives no `res_valid`.
- R9: `res_miss` is 0 for every bypass or direct-mapped result.
- R10: After reset, with no access, `res_valid`, `busy` and `pg_req` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | One-cycle access pulse |
| acc_vaddr | input | 32 | Virtual address of the access |
| glb_cfg | input | 32 | Global configuration; bits 3:2 switch translation on |
| mmu_cfg | input | 32 | Bits 15:0 mark segments as direct-mapped |
| seg_base_lo | input | 32 | Base nibbles for segments 0 to 7 |
| seg_base_hi | input | 32 | Base nibbles for segments 8 to 15 |
| pg_req | output | 1 | Request to the paged lookup path |
| pg_vaddr | output | 32 | Address forwarded to the page path |
| pg_rsp_valid | input | 1 | Page path answer valid |
| pg_rsp_pfn | input | 19 | Page frame number from the page path |
| pg_rsp_perm | input | 3 | Rights from the page path (read, write, exec) |
| pg_rsp_miss | input | 1 | Miss flag from the page path |
| res_valid | output | 1 | Result valid |
| res_paddr | output | 32 | Physical address |
| res_perm | output | 3 | Granted rights: bit 0 read, bit 1 write, bit 2 exec |
| res_miss | output | 1 | Translation miss |
| busy | output | 1 | A paged lookup is open |

## Verification
The bench sets `glb_cfg` with every bit except 3:2 high, and checks that translation stays off. A decoder that tested the whole word for nonzero would switch translation on. It sets each enable bit alone and checks that either one is enough. It checks segments on both sides of the 7/8 split and at the top nibble slot. A design that indexed the wrong base word, or used s rather than s mod 8, would put the wrong base nibble on the address. Paged tests check that the result comes exactly one cycle after the answer, that the miss flag and the rights pass through, and that an answer arriving while no request is open produces no result.

// File: rtl/seg_xlate_pkg.sv
// Shared types for the segment-mapped translator.
// Assumes nothing beyond what is declared here.
package seg_xlate_pkg;

    // Route an access takes through the translator
    typedef enum logic [1:0] {
        XL_BYPASS  = 2'd0,
        XL_SEGMENT = 2'd1,
        XL_PAGED   = 2'd2
    } xl_mode_e;

    // Rights vector: bit 0 read, bit 1 write, bit 2 exec
    localparam int unsigned PERM_W = 3;
    localparam logic [PERM_W-1:0] PERM_ALL  = 3'b111;
    localparam logic [PERM_W-1:0] PERM_NONE = 3'b000;

endpackage

// File: rtl/seg_xlate_mode_dec.sv
// Route decoder: picks bypass, fixed segment mapping or paged lookup.
// Assumes en_bits carries the two translation-enable bits of the global
// configuration, and seg_map carries one direct-map flag per segment.
module seg_xlate_mode_dec
    import seg_xlate_pkg::*;
#(
    parameter int unsigned SEG_W = 4,
    localparam int unsigned NSEG = 1 << SEG_W
) (
    input  logic [1:0]      en_bits,
    input  logic [NSEG-1:0] seg_map,
    input  logic [SEG_W-1:0] seg,
    output logic            mmu_on,
    output xl_mode_e        mode
);

    // Either enable bit switches translation on
    always_comb begin
        mmu_on = |en_bits;
    end

    // Pick the route from the enable state and the segment flag
    always_comb begin
        if (!mmu_on) begin
            mode = XL_BYPASS;
        end else if (seg_map[seg]) begin
            mode = XL_SEGMENT;
        end else begin
            mode = XL_PAGED;
        end
    end

endmodule

// File: rtl/seg_xlate_base_sel.sv
// Segment base selector: returns the physical base nibble for a segment.
// Assumes the lower half of the segments is packed into base_lo and the
// upper half into base_hi, nibble k of a word at bits [k*NIB_W +: NIB_W].
module seg_xlate_base_sel #(
    parameter int unsigned SEG_W = 4,
    parameter int unsigned NIB_W = 4,
    localparam int unsigned NSEG    = 1 << SEG_W,
    localparam int unsigned PER_REG = NSEG / 2,
    localparam int unsigned REG_W   = PER_REG * NIB_W
) (
    input  logic [REG_W-1:0] base_lo,
    input  logic [REG_W-1:0] base_hi,
    input  logic [SEG_W-1:0] seg,
    output logic [NIB_W-1:0] base_nib
);

    logic [NIB_W-1:0] nib_arr [NSEG];

    // Unpack every segment's nibble from the word that holds it
    for (genvar g = 0; g < NSEG; g++) begin : g_nib
        if (g < PER_REG) begin : g_lo
            assign nib_arr[g] = base_lo[(g % PER_REG)*NIB_W +: NIB_W];
        end else begin : g_hi
            assign nib_arr[g] = base_hi[(g % PER_REG)*NIB_W +: NIB_W];
        end
    end

    // Select the nibble of the addressed segment
    always_comb begin
        base_nib = nib_arr[seg];
    end

endmodule

// File: rtl/seg_xlate_page_if.sv
// Page-path interface: tracks the open lookup and registers its answer.
// Assumes at most one lookup is open at a time, and that the caller waits
// for busy to drop. Answers with no open lookup are dropped.
module seg_xlate_page_if
    import seg_xlate_pkg::*;
#(
    parameter int unsigned VA_W       = 32,
    parameter int unsigned PAGE_SHIFT = 13,
    localparam int unsigned PFN_W     = VA_W - PAGE_SHIFT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue,
    input  logic              rsp_valid,
    input  logic [PFN_W-1:0]  rsp_pfn,
    input  logic [PERM_W-1:0] rsp_perm,
    input  logic              rsp_miss,
    output logic              out_valid,
    output logic [VA_W-1:0]   out_paddr,
    output logic [PERM_W-1:0] out_perm,
    output logic              out_miss,
    output logic              busy
);

    logic              open_r;
    logic              rv_r;
    logic [PFN_W-1:0]  pfn_r;
    logic [PERM_W-1:0] perm_r;
    logic              miss_r;
    logic              take;

    // An answer counts only while a lookup is open
    always_comb begin
        take = rsp_valid && open_r;
    end

    // Open on issue, close on an accepted answer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_r <= 1'b0;
        end else if (issue) begin
            open_r <= 1'b1;
        end else if (take) begin
            open_r <= 1'b0;
        end
    end

    // Present the accepted answer for exactly one cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rv_r <= 1'b0;
        end else begin
            rv_r <= take;
        end
    end

    // Capture the answer fields
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pfn_r  <= '0;
            perm_r <= PERM_NONE;
            miss_r <= 1'b0;
        end else if (take) begin
            pfn_r  <= rsp_pfn;
            perm_r <= rsp_perm;
            miss_r <= rsp_miss;
        end
    end

    // Expand the frame number into a byte address
    always_comb begin
        out_valid = rv_r;
        out_paddr = {pfn_r, {PAGE_SHIFT{1'b0}}};
        out_perm  = perm_r;
        out_miss  = miss_r;
        busy      = open_r || rv_r;
    end

    AST_RSP_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && busy && !out_valid) |=> out_valid) else $error("AST_RSP_NEXT_CYCLE"); // R7
    AST_RSP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid) else $error("AST_RSP_SINGLE"); // R7
    AST_STRAY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !issue) |=> !out_valid) else $error("AST_STRAY_DROP"); // R8

endmodule

// File: rtl/seg_xlate.sv
// Segment-mapped address translator, first stage.
// Bypass and direct-mapped routes answer in the same cycle with full rights.
// Paged accesses go to an external lookup path whose answer is registered.
// Assumes acc_valid is a one-cycle pulse given only while busy is low.
module seg_xlate
    import seg_xlate_pkg::*;
#(
    parameter int unsigned VA_W       = 32,
    parameter int unsigned SEG_W      = 4,
    parameter int unsigned PAGE_SHIFT = 13,
    parameter int unsigned CFG_W      = 32,
    parameter int unsigned EN_BIT_LO  = 2,
    localparam int unsigned NIB_W     = SEG_W,
    localparam int unsigned OFF_W     = VA_W - SEG_W,
    localparam int unsigned PFN_W     = VA_W - PAGE_SHIFT,
    localparam int unsigned NSEG      = 1 << SEG_W,
    localparam int unsigned REG_W     = (NSEG / 2) * NIB_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic [VA_W-1:0]   acc_vaddr,
    input  logic [CFG_W-1:0]  glb_cfg,
    input  logic [CFG_W-1:0]  mmu_cfg,
    input  logic [REG_W-1:0]  seg_base_lo,
    input  logic [REG_W-1:0]  seg_base_hi,
    output logic              pg_req,
    output logic [VA_W-1:0]   pg_vaddr,
    input  logic              pg_rsp_valid,
    input  logic [PFN_W-1:0]  pg_rsp_pfn,
    input  logic [PERM_W-1:0] pg_rsp_perm,
    input  logic              pg_rsp_miss,
    output logic              res_valid,
    output logic [VA_W-1:0]   res_paddr,
    output logic [PERM_W-1:0] res_perm,
    output logic              res_miss,
    output logic              busy
);

    logic [SEG_W-1:0]  seg;
    logic              mmu_on;
    xl_mode_e          mode;
    logic [NIB_W-1:0]  base_nib;
    logic              pv_valid;
    logic [VA_W-1:0]   pv_paddr;
    logic [PERM_W-1:0] pv_perm;
    logic              pv_miss;
    logic              cfg_unused;

    // Configuration bits that take no part in routing
    assign cfg_unused = ^{glb_cfg[CFG_W-1:EN_BIT_LO+2], glb_cfg[EN_BIT_LO-1:0],
                          mmu_cfg[CFG_W-1:NSEG]};

    // Segment number is the top field of the address
    always_comb begin
        seg = acc_vaddr[VA_W-1 -: SEG_W];
    end

    seg_xlate_mode_dec #(
        .SEG_W(SEG_W)
    ) u_dec (
        .en_bits (glb_cfg[EN_BIT_LO +: 2]),
        .seg_map (mmu_cfg[NSEG-1:0]),
        .seg     (seg),
        .mmu_on  (mmu_on),
        .mode    (mode)
    );

    seg_xlate_base_sel #(
        .SEG_W(SEG_W),
        .NIB_W(NIB_W)
    ) u_base (
        .base_lo  (seg_base_lo),
        .base_hi  (seg_base_hi),
        .seg      (seg),
        .base_nib (base_nib)
    );

    // Raise a lookup request for accesses on the paged route
    always_comb begin
        pg_req   = acc_valid && (mode == XL_PAGED);
        pg_vaddr = acc_vaddr;
    end

    seg_xlate_page_if #(
        .VA_W      (VA_W),
        .PAGE_SHIFT(PAGE_SHIFT)
    ) u_pif (
        .clk       (clk),
        .rst_n     (rst_n),
        .issue     (pg_req),
        .rsp_valid (pg_rsp_valid),
        .rsp_pfn   (pg_rsp_pfn),
        .rsp_perm  (pg_rsp_perm),
        .rsp_miss  (pg_rsp_miss),
        .out_valid (pv_valid),
        .out_paddr (pv_paddr),
        .out_perm  (pv_perm),
        .out_miss  (pv_miss),
        .busy      (busy)
    );

    // Merge the registered page answer with the same-cycle routes
    always_comb begin
        res_valid = 1'b0;
        res_paddr = '0;
        res_perm  = PERM_NONE;
        res_miss  = 1'b0;
        if (pv_valid) begin
            res_valid = 1'b1;
            res_paddr = pv_paddr;
            res_perm  = pv_perm;
            res_miss  = pv_miss;
        end else if (acc_valid && mode == XL_BYPASS) begin
            res_valid = 1'b1;
            res_paddr = acc_vaddr;
            res_perm  = PERM_ALL;
        end else if (acc_valid && mode == XL_SEGMENT) begin
            res_valid = 1'b1;
            res_paddr = {base_nib, acc_vaddr[OFF_W-1:0]};
            res_perm  = PERM_ALL;
        end
    end

    AST_BYPASS_IDENT: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !mmu_on && !pv_valid) |-> (res_valid && res_paddr == acc_vaddr && !pg_req)) else $error("AST_BYPASS_IDENT"); // R1
    AST_SEG_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && mode == XL_SEGMENT && !pv_valid) |-> (res_paddr[OFF_W-1:0] == acc_vaddr[OFF_W-1:0])) else $error("AST_SEG_OFFSET_KEPT"); // R5
    AST_DIRECT_NO_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !pg_req && !pv_valid) |-> (!res_miss && res_perm == PERM_ALL)) else $error("AST_DIRECT_NO_MISS"); // R9
    AST_REQ_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        pg_req |=> busy) else $error("AST_REQ_SETS_BUSY"); // R8
    AST_NO_ISSUE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !acc_valid) else $error("AST_NO_ISSUE_BUSY"); // R8

endmodule

// File: tb/seg_xlate_bench.sv
module seg_xlate_bench;

    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic [31:0] acc_vaddr = '0;
    logic [31:0] glb_cfg = '0;
    logic [31:0] mmu_cfg = '0;
    logic [31:0] seg_base_lo = 32'hFEDCBA98;
    logic [31:0] seg_base_hi = 32'h13579BDF;
    logic        pg_req;
    logic [31:0] pg_vaddr;
    logic        pg_rsp_valid = 1'b0;
    logic [18:0] pg_rsp_pfn = '0;
    logic [2:0]  pg_rsp_perm = '0;
    logic        pg_rsp_miss = 1'b0;
    logic        res_valid;
    logic [31:0] res_paddr;
    logic [2:0]  res_perm;
    logic        res_miss;
    logic        busy;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    seg_xlate u_seg_xlate (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_vaddr(acc_vaddr),
        .glb_cfg(glb_cfg), .mmu_cfg(mmu_cfg), .seg_base_lo(seg_base_lo),
        .seg_base_hi(seg_base_hi), .pg_req(pg_req), .pg_vaddr(pg_vaddr),
        .pg_rsp_valid(pg_rsp_valid), .pg_rsp_pfn(pg_rsp_pfn),
        .pg_rsp_perm(pg_rsp_perm), .pg_rsp_miss(pg_rsp_miss),
        .res_valid(res_valid), .res_paddr(res_paddr), .res_perm(res_perm),
        .res_miss(res_miss), .busy(busy)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [3:0] base_of(input logic [3:0] s);
        logic [31:0] w;
        w = (s < 4'd8) ? seg_base_lo : seg_base_hi;
        return w[(s % 8)*4 +: 4];
    endfunction

    // Drive an access after the falling edge and settle before sampling
    task automatic drive_acc(input logic [31:0] va);
        @(negedge clk);
        acc_valid = 1'b1;
        acc_vaddr = va;
        #1;
    endtask

    task automatic end_acc();
        @(negedge clk);
        acc_valid = 1'b0;
        #1;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk("R10", "res_valid", {31'd0, res_valid}, 32'd0);
        chk("R10", "busy", {31'd0, busy}, 32'd0);
        chk("R10", "pg_req", {31'd0, pg_req}, 32'd0);
    endtask

    task automatic t_bypass();
        glb_cfg = 32'hFFFF_FFF3;
        mmu_cfg = 32'hFFFF_FFFF;
        drive_acc(32'h9ABC_DEF1);
        chk("R1", "res_valid", {31'd0, res_valid}, 32'd1);
        chk("R1", "paddr", res_paddr, 32'h9ABC_DEF1);
        chk("R1", "perm", {29'd0, res_perm}, 32'd7);
        chk("R9", "miss", {31'd0, res_miss}, 32'd0);
        chk("R2", "pg_req", {31'd0, pg_req}, 32'd0);
        end_acc();
    endtask

    task automatic t_enable_bits();
        mmu_cfg = 32'h0000_0001;
        glb_cfg = 32'h0000_0004;
        drive_acc(32'h0123_4567);
        chk("R2", "bit2 seg paddr", res_paddr, {base_of(4'd0), 28'h123_4567});
        end_acc();
        glb_cfg = 32'h0000_0008;
        drive_acc(32'h0123_4567);
        chk("R2", "bit3 seg paddr", res_paddr, {base_of(4'd0), 28'h123_4567});
        end_acc();
    endtask

    task automatic t_segments();
        glb_cfg = 32'h0000_000C;
        mmu_cfg = 32'h0000_A1E8;
        for (int s = 0; s < 16; s++) begin
            logic [31:0] va;
            va = {s[3:0], 28'hA5C_3E7};
            if (mmu_cfg[s]) begin
                drive_acc(va);
                chk("R4", "seg paddr", res_paddr, {base_of(s[3:0]), 28'hA5C_3E7});
                chk("R5", "seg perm", {29'd0, res_perm}, 32'd7);
                chk("R9", "seg miss", {31'd0, res_miss}, 32'd0);
                chk("R5", "seg pg_req", {31'd0, pg_req}, 32'd0);
                end_acc();
            end
        end
    endtask

    task automatic t_paged(input logic [31:0] va, input logic [18:0] pfn,
                           input logic [2:0] perm, input logic miss);
        glb_cfg = 32'h0000_0004;
        mmu_cfg = 32'h0000_0020;
        drive_acc(va);
        chk("R3", "pg_req", {31'd0, pg_req}, 32'd1);
        chk("R6", "pg_vaddr", pg_vaddr, va);
        chk("R6", "no res", {31'd0, res_valid}, 32'd0);
        end_acc();
        chk("R8", "busy open", {31'd0, busy}, 32'd1);
        chk("R8", "no res yet", {31'd0, res_valid}, 32'd0);
        @(negedge clk);
        pg_rsp_valid = 1'b1;
        pg_rsp_pfn = pfn;
        pg_rsp_perm = perm;
        pg_rsp_miss = miss;
        #1;
        chk("R7", "res not same cycle", {31'd0, res_valid}, 32'd0);
        @(negedge clk);
        pg_rsp_valid = 1'b0;
        pg_rsp_pfn = '0;
        pg_rsp_perm = '0;
        pg_rsp_miss = 1'b0;
        #1;
        chk("R7", "res valid", {31'd0, res_valid}, 32'd1);
        chk("R7", "paddr", res_paddr, {pfn, 13'd0});
        chk("R7", "perm", {29'd0, perm}, {29'd0, res_perm});
        chk("R7", "miss", {31'd0, res_miss}, {31'd0, miss});
        chk("R8", "busy at result", {31'd0, busy}, 32'd1);
        @(negedge clk);
        #1;
        chk("R7", "res one cycle", {31'd0, res_valid}, 32'd0);
        chk("R8", "busy cleared", {31'd0, busy}, 32'd0);
    endtask

    task automatic t_stray();
        @(negedge clk);
        pg_rsp_valid = 1'b1;
        pg_rsp_pfn = 19'h7FFFF;
        pg_rsp_miss = 1'b1;
        @(negedge clk);
        pg_rsp_valid = 1'b0;
        pg_rsp_miss = 1'b0;
        #1;
        chk("R8", "stray res", {31'd0, res_valid}, 32'd0);
        chk("R8", "stray busy", {31'd0, busy}, 32'd0);
    endtask

    initial begin
        t_reset();
        t_bypass();
        t_enable_bits();
        t_segments();
        t_paged(32'h2345_6789, 19'h5A5A5, 3'b011, 1'b0);
        t_paged(32'hE000_2000, 19'h00001, 3'b000, 1'b1);
        t_stray();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule